// File: doc/BRIEF.md
# SPI Word FIFOs with Threshold Interrupts

This block holds the transmit and receive queues of a serial peripheral controller. Both queues are built on a buffer of a fixed number of bytes. The word-size select sets how many words each queue holds. The register interface pushes words into the transmit queue, and the shift engine pops them from there. The shift engine pushes received words into the receive queue, and the register interface pops them. The serial shifter and the register decode sit outside this block.

Each queue reports its fill level. Each queue also raises a level-sensitive interrupt request. A 2-bit mode picks the fill condition for each request. A receive word that arrives while the receive queue is full is dropped, and the block sets a sticky overflow flag. Two events empty both queues: a change of word size, and clearing the enable input.

Top module: `spi_word_fifos`

## Requirements
- R1: Each queue holds at most 16, 8 or 4 words when `word_sel` is 0 (8-bit), 1 (16-bit), or 2 or 3 (32-bit). A push to a full queue without a simultaneous pop leaves the queue unchanged.
- R2: Words leave a queue in the order they entered. Each stored word keeps only the low 8, 16 or 32 bits of its input, and the upper bits read as zero.
- R3: `tx_level` and `rx_level` give the current word count one cycle after the push or pop that changed it. `rx_empty` is 1 exactly when the receive level is 0. After reset both levels are 0.
- R4: `rx_irq` follows `rx_irq_mode`. Mode 0 fires when the queue is empty, mode 1 when it is not empty, mode 2 when it is at least half of capacity, and mode 3 when it is at capacity.
- R5: `tx_irq` follows `tx_irq_mode`. Mode 0 fires when the queue is empty and `shifter_busy` is 0, mode 1 when the queue is empty, mode 2 when the free space is at least half of capacity, and mode 3 when at least one slot is free.
- R6: A receive push into a full receive queue without a simultaneous pop sets `rx_overflow` in the next cycle. The word is discarded and the queue keeps its contents. The flag stays set until `ovf_clear` is pulsed, and a new overflow in the same cycle as the clear wins.
- R7: A cycle with `enable` low, or with `word_sel` different from its value in the previous cycle, empties both queues at the next edge and accepts no push. While `enable` is low both interrupt requests are 0.
- R8: A pop from an empty queue has no effect. An empty queue presents zero on its read data.
- R9: A push and a pop in the same cycle on a full queue are both accepted. The level stays the same and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module on; low flushes both queues |
| word_sel | input | 2 | Word size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| tx_irq_mode | input | 2 | Transmit interrupt condition |
| rx_irq_mode | input | 2 | Receive interrupt condition |
| shifter_busy | input | 1 | Shift engine still holds a word |
| tx_push | input | 1 | Register write into transmit queue |
| tx_wdata | input | 32 | Transmit write word |
| tx_pop | input | 1 | Shift engine takes a transmit word |
| tx_rdata | output | 32 | Head of transmit queue |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_wdata | input | 32 | Received word |
| rx_pop | input | 1 | Register read from receive queue |
| rx_rdata | output | 32 | Head of receive queue |
| ovf_clear | input | 1 | Clears the overflow flag |
| tx_level | output | 5 | Transmit word count |
| rx_level | output | 5 | Receive word count |
| rx_empty | output | 1 | Receive queue empty |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench fills each queue to the capacity of every word size. A design that sized capacity in entries instead of bytes would accept extra words and show levels above 8 or 4. It pushes and pops together on a full receive queue, where a wrong full test would raise a false overflow or drop the word. It changes the word size while data is queued, which a missed flush would expose as stale or wrongly masked words. It drives `shifter_busy` while the transmit queue is empty in mode 0, where a design that ignored the shifter would fire early. It also pops empty queues, which catches pointer underflow and nonzero read data.

// File: rtl/spwf_pkg.sv
// Shared definitions for the SPI word FIFO block.
// Assumes the data path is at most 32 bits wide.
package spwf_pkg;

    typedef enum logic [1:0] {
        WS_BYTE  = 2'd0,
        WS_HALF  = 2'd1,
        WS_WORD  = 2'd2,
        WS_WORD2 = 2'd3
    } wsel_e;

    // Keep only the active low bits of a word for the selected size.
    function automatic logic [31:0] trim_word(input logic [1:0] ws, input logic [31:0] d);
        case (ws)
            WS_BYTE: trim_word = {24'd0, d[7:0]};
            WS_HALF: trim_word = {16'd0, d[15:0]};
            default: trim_word = d;
        endcase
    endfunction

    // log2 of bytes per word for a size selection.
    function automatic int unsigned byte_shift(input logic [1:0] ws);
        case (ws)
            WS_BYTE: byte_shift = 0;
            WS_HALF: byte_shift = 1;
            default: byte_shift = 2;
        endcase
    endfunction

endpackage

// File: rtl/spwf_fifo.sv
// Circular word queue with a run-time capacity limit.
// Assumes DEPTH is a power of two and cap never exceeds DEPTH.
// A push into a full queue is accepted only when a pop happens in
// the same cycle; otherwise it is dropped and push_lost pulses.
module spwf_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [LVL_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              push_lost
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [LVL_W-1:0]  cnt;
    logic              pop_ok, push_ok;

    // Accept decisions for this cycle.
    always_comb begin
        pop_ok    = pop && (cnt != '0) && !flush;
        push_ok   = push && !flush && ((cnt < cap) || pop_ok);
        push_lost = push && !flush && !push_ok;
    end

    // Storage write; no reset needed on the array.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and count update with flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
            if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            cnt <= cnt + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    // Head word, zero when empty.
    always_comb begin
        rdata = (cnt != '0) ? mem[rd_ptr] : '0;
        level = cnt;
    end

endmodule

// File: rtl/spwf_irq.sv
// Interrupt condition selector for one queue.
// IS_TX picks the transmit set of conditions (free-space based,
// mode 0 also waits for the shifter); otherwise the receive set.
module spwf_irq #(
    parameter int LVL_W = 5,
    parameter bit IS_TX = 1'b0
) (
    input  logic [1:0]       mode,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] cap,
    input  logic             enable,
    input  logic             shifter_busy,
    output logic             irq
);
    logic [LVL_W-1:0] half;
    logic [LVL_W-1:0] room;
    logic             cond;

    // Derived quantities shared by both variants.
    always_comb begin
        half = cap >> 1;
        room = cap - level;
    end

    generate
        if (IS_TX) begin : g_tx
            // Transmit condition by mode.
            always_comb begin
                case (mode)
                    2'd0:    cond = (level == '0) && !shifter_busy;
                    2'd1:    cond = (level == '0);
                    2'd2:    cond = (room >= half);
                    default: cond = (room != '0);
                endcase
            end
        end else begin : g_rx
            // Receive condition by mode.
            always_comb begin
                case (mode)
                    2'd0:    cond = (level == '0);
                    2'd1:    cond = (level != '0);
                    2'd2:    cond = (level >= half);
                    default: cond = (level == cap);
                endcase
            end
        end
    endgenerate

    // Gate with module enable.
    always_comb irq = enable && cond;

endmodule

// File: rtl/spi_word_fifos.sv
// Transmit and receive word queues over a FIFO_BYTES buffer each,
// with level reporting, threshold interrupts and receive overflow.
// Assumes FIFO_BYTES is a power of two of at least 4.
module spi_word_fifos
    import spwf_pkg::*;
#(
    parameter int FIFO_BYTES = 16,
    parameter int LVL_W      = $clog2(FIFO_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       word_sel,
    input  logic [1:0]       tx_irq_mode,
    input  logic [1:0]       rx_irq_mode,
    input  logic             shifter_busy,
    input  logic             tx_push,
    input  logic [31:0]      tx_wdata,
    input  logic             tx_pop,
    output logic [31:0]      tx_rdata,
    input  logic             rx_push,
    input  logic [31:0]      rx_wdata,
    input  logic             rx_pop,
    output logic [31:0]      rx_rdata,
    input  logic             ovf_clear,
    output logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] rx_level,
    output logic             rx_empty,
    output logic             rx_overflow,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam int DEPTH = FIFO_BYTES;

    logic [1:0]       ws_q;
    logic             flush;
    logic [LVL_W-1:0] cap;
    logic [31:0]      tx_in, rx_in;
    logic             rx_lost, tx_lost_unused;
    logic             ovf_q;

    // Flush on disable or word-size change; capacity from size.
    always_comb begin
        flush = !enable || (word_sel != ws_q);
        cap   = LVL_W'(FIFO_BYTES >> byte_shift(word_sel));
        tx_in = trim_word(word_sel, tx_wdata);
        rx_in = trim_word(word_sel, rx_wdata);
    end

    // Remember the last word size.
    always_ff @(posedge clk) begin
        if (!rst_n) ws_q <= WS_BYTE;
        else        ws_q <= word_sel;
    end

    spwf_fifo #(.DEPTH(DEPTH), .DATA_W(32), .LVL_W(LVL_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(tx_push), .wdata(tx_in), .pop(tx_pop),
        .rdata(tx_rdata), .level(tx_level), .push_lost(tx_lost_unused)
    );

    spwf_fifo #(.DEPTH(DEPTH), .DATA_W(32), .LVL_W(LVL_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(rx_push), .wdata(rx_in), .pop(rx_pop),
        .rdata(rx_rdata), .level(rx_level), .push_lost(rx_lost)
    );

    // Sticky overflow; a new loss beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= (ovf_q && !ovf_clear) || rx_lost;
    end

    spwf_irq #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_irq (
        .mode(tx_irq_mode), .level(tx_level), .cap(cap), .enable(enable),
        .shifter_busy(shifter_busy), .irq(tx_irq)
    );

    spwf_irq #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_irq (
        .mode(rx_irq_mode), .level(rx_level), .cap(cap), .enable(enable),
        .shifter_busy(shifter_busy), .irq(rx_irq)
    );

    // Status outputs.
    always_comb begin
        rx_empty    = (rx_level == '0);
        rx_overflow = ovf_q;
    end

endmodule

// File: rtl/spwf_chk.sv
// Property checker for spi_word_fifos, attached by bind.
module spwf_chk #(
    parameter int FIFO_BYTES = 16,
    parameter int LVL_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [1:0]       word_sel,
    input logic [1:0]       tx_irq_mode,
    input logic             shifter_busy,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             ovf_clear,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_overflow,
    input logic             tx_irq,
    input logic             rx_irq
);
    logic [LVL_W-1:0] cap_c;

    // Independent capacity for the selected size.
    always_comb begin
        case (word_sel)
            2'd0:    cap_c = LVL_W'(FIFO_BYTES);
            2'd1:    cap_c = LVL_W'(FIFO_BYTES / 2);
            default: cap_c = LVL_W'(FIFO_BYTES / 4);
        endcase
    end

    // R1
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(word_sel) |-> (tx_level <= cap_c) && (rx_level <= cap_c));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $stable(word_sel) && rx_push && !rx_pop && rx_level == cap_c)
        |=> (rx_overflow && $stable(rx_level)));

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !ovf_clear) |=> rx_overflow);

    // R7
    off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tx_level == '0) && (rx_level == '0));

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!tx_irq && !rx_irq));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq_mode == 2'd0 && shifter_busy) |-> !tx_irq);

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_level == '0) |=> (rx_level == '0));

endmodule

bind spi_word_fifos spwf_chk #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/spi_word_fifos_bench.sv
module spi_word_fifos_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [1:0]  word_sel, tx_irq_mode, rx_irq_mode;
    logic        shifter_busy, tx_push, tx_pop, rx_push, rx_pop, ovf_clear;
    logic [31:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic [4:0]  tx_level, rx_level;
    logic        rx_empty, rx_overflow, tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    bit          ovf_m;
    logic [1:0]  ws_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_word_fifos u_spi_word_fifos (
        .clk(clk), .rst_n(rst_n), .enable(enable), .word_sel(word_sel),
        .tx_irq_mode(tx_irq_mode), .rx_irq_mode(rx_irq_mode),
        .shifter_busy(shifter_busy), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .rx_push(rx_push),
        .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .ovf_clear(ovf_clear), .tx_level(tx_level), .rx_level(rx_level),
        .rx_empty(rx_empty), .rx_overflow(rx_overflow),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    function automatic int exp_cap(input logic [1:0] ws);
        return (ws == 2'd0) ? 16 : (ws == 2'd1) ? 8 : 4;
    endfunction

    function automatic logic [31:0] exp_trim(input logic [1:0] ws, input logic [31:0] d);
        if (ws == 2'd0) return d & 32'hFF;
        if (ws == 2'd1) return d & 32'hFFFF;
        return d;
    endfunction

    function automatic bit exp_rx_irq(input logic [1:0] m, input int lv, input int cp, input bit en);
        bit c;
        case (m)
            2'd0: c = (lv == 0);
            2'd1: c = (lv != 0);
            2'd2: c = (2 * lv >= cp);
            default: c = (lv == cp);
        endcase
        return en && c;
    endfunction

    function automatic bit exp_tx_irq(input logic [1:0] m, input int lv, input int cp, input bit en, input bit busy);
        bit c;
        case (m)
            2'd0: c = (lv == 0) && !busy;
            2'd1: c = (lv == 0);
            2'd2: c = (2 * (cp - lv) >= cp);
            default: c = (lv < cp);
        endcase
        return en && c;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; ovf_clear = 0;
        tx_wdata = '0; rx_wdata = '0;
    endtask

    // Check all outputs against the model (sampled 1 time unit after the edge).
    task automatic check_all();
        int cp;
        cp = exp_cap(word_sel);
        chk("R3 tx_level", tx_level, txq.size());
        chk("R3 rx_level", rx_level, rxq.size());
        chk("R3 rx_empty", rx_empty, rxq.size() == 0);
        chk("R6 overflow", rx_overflow, ovf_m);
        chk("R5 tx_irq", tx_irq, exp_tx_irq(tx_irq_mode, txq.size(), cp, enable, shifter_busy));
        chk("R4 rx_irq", rx_irq, exp_rx_irq(rx_irq_mode, rxq.size(), cp, enable));
        chk("R2 tx_rdata", tx_rdata, txq.size() ? txq[0] : 32'h0);
        chk("R2 rx_rdata", rx_rdata, rxq.size() ? rxq[0] : 32'h0);
    endtask

    // Advance one clock, applying the current inputs to the model.
    task automatic cycle();
        bit fl, tpo, tpu, rpo, rpu, rset;
        int cp;
        cp   = exp_cap(word_sel);
        fl   = !enable || (word_sel != ws_prev);
        rset = 0;
        if (fl) begin
            txq.delete();
            rxq.delete();
        end else begin
            tpo = tx_pop && txq.size() > 0;
            tpu = tx_push && (txq.size() < cp || tpo);
            if (tpo) void'(txq.pop_front());
            if (tpu) txq.push_back(exp_trim(word_sel, tx_wdata));
            rpo = rx_pop && rxq.size() > 0;
            rpu = rx_push && (rxq.size() < cp || rpo);
            if (rpo) void'(rxq.pop_front());
            if (rpu) rxq.push_back(exp_trim(word_sel, rx_wdata));
            rset = rx_push && !rpu;
        end
        ovf_m   = (ovf_m && !ovf_clear) || rset;
        ws_prev = word_sel;
        @(posedge clk);
        #1;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        rst_n = 0; enable = 1; word_sel = 2'd0; tx_irq_mode = 2'd0;
        rx_irq_mode = 2'd0; shifter_busy = 0;
        idle_inputs();
        ovf_m = 0; ws_prev = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // Reset state (R3)
        chk("R3 reset tx_level", tx_level, 0);
        chk("R3 reset rx_level", rx_level, 0);
        chk("R6 reset overflow", rx_overflow, 0);

        // R8: pop empty queues
        rx_pop = 1; tx_pop = 1;
        cycle();
        chk("R8 rx_rdata empty", rx_rdata, 0);
        chk("R8 rx_level empty", rx_level, 0);
        idle_inputs();

        // R1 + R2: 16-bit mode, push 10 words into both queues
        word_sel = 2'd1; cycle();
        for (int i = 0; i < 10; i++) begin
            tx_push = 1; rx_push = 1;
            tx_wdata = 32'hA5A5_0000 + i; rx_wdata = 32'h1234_0100 + i;
            cycle();
        end
        idle_inputs();
        chk("R1 tx cap 16-bit", tx_level, 8);
        chk("R2 trim 16-bit", tx_rdata, 32'h0000_0000);
        chk("R6 overflow after extra rx", rx_overflow, 1);
        chk("R6 contents kept", rx_rdata, 32'h0000_0100);

        // R9: push+pop on full receive queue, clear flag first
        ovf_clear = 1; cycle(); idle_inputs();
        chk("R6 cleared", rx_overflow, 0);
        rx_push = 1; rx_pop = 1; rx_wdata = 32'h0000_BEEF; cycle(); idle_inputs();
        chk("R9 level held", rx_level, 8);
        chk("R9 no overflow", rx_overflow, 0);

        // R7: word-size change flushes
        word_sel = 2'd2; cycle();
        chk("R7 flush tx", tx_level, 0);
        chk("R7 flush rx", rx_level, 0);

        // R5: mode 0 waits for the shifter
        tx_irq_mode = 2'd0; shifter_busy = 1; cycle();
        chk("R5 busy blocks", tx_irq, 0);
        shifter_busy = 0; cycle();
        chk("R5 idle fires", tx_irq, 1);

        // R4: full in 32-bit mode
        rx_irq_mode = 2'd3;
        for (int i = 0; i < 4; i++) begin
            rx_push = 1; rx_wdata = $urandom(); cycle();
        end
        idle_inputs();
        chk("R4 full irq", rx_irq, 1);

        // R7: disable flushes and silences
        enable = 0; cycle();
        chk("R7 off level", rx_level, 0);
        chk("R7 off irq", tx_irq, 0);
        enable = 1; cycle();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int pp;
            pp = ((n / 256) % 2) ? 70 : 30;
            if ($urandom_range(199) == 0) word_sel = 2'($urandom());
            enable = ($urandom_range(149) != 0);
            if (n % 50 == 0) begin
                tx_irq_mode = 2'($urandom());
                rx_irq_mode = 2'($urandom());
            end
            shifter_busy = $urandom_range(1);
            tx_push   = ($urandom_range(99) < pp);
            rx_push   = ($urandom_range(99) < pp);
            tx_pop    = ($urandom_range(99) < 100 - pp);
            rx_pop    = ($urandom_range(99) < 100 - pp);
            ovf_clear = ($urandom_range(39) == 0);
            tx_wdata  = $urandom();
            rx_wdata  = $urandom();
            cycle();
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule